// File: doc/BRIEF.md
# Grey Nibble Scan-Out Expander

This block reads a 4-bit-per-pixel grey framebuffer and turns it into a pixel stream for a host display. Each framebuffer byte holds two pixels. The block converts each grey nibble to one of three output colour formats. It then magnifies the image by repeating every source pixel across a line and every line down the frame, by the same factor. With the default sizes (64 rows of 64 bytes, factor 4), one scan produces a 512 × 256 image.

A scan is driven by a redraw flag that the host owns. While the flag is low the block is idle: it makes no memory reads and presents no pixels. When the flag is high the block scans one complete frame. It then pulses an acknowledge so the host can clear the flag. Framebuffer bytes come from a read port with one cycle of latency. Pixels leave through a valid/ready handshake, with start-of-frame and end-of-line markers attached to the matching pixels.

Top module: `gnx_scan_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pixValid`, `redrawAck` and `memRdEn` are all low.
- R2: While `redrawReq` is low and no frame is in progress, the block makes no memory read and presents no pixel.
- R3: Within a byte, bits [7:4] form the left pixel and bits [3:0] form the right pixel. Byte b of source row r is read from address r·SRC_BYTES + b, and no address at or beyond SRC_ROWS·SRC_BYTES is ever read.
- R4: With `fmtSel` = 2'b10 or 2'b11 (24-bit), `pixData` = {c, c, c}, where the 8-bit channel c = (n<<4)|n for nibble n.
- R5: With `fmtSel` = 2'b00 (RGB555), `pixData`[14:10], [9:5] and [4:0] each hold the level L = 2n + n[3], and bits [23:15] are zero.
- R6: With `fmtSel` = 2'b01 (RGB565), `pixData`[15:11] and [4:0] hold L, [10:5] hold (L<<1)|L[4], and bits [23:16] are zero.
- R7: Each source pixel is emitted MAG times in a row, and each output line is emitted MAG times. One frame is exactly 2·SRC_BYTES·MAG × SRC_ROWS·MAG accepted pixels, in raster order.
- R8: While `pixValid` is high and `pixReady` is low, `pixValid`, `pixData`, `pixSof` and `pixEol` hold their values into the next cycle.
- R9: `pixSof` is high only with the first pixel of a frame. `pixEol` is high only with the last pixel of each output line. Neither marker is high without `pixValid`.
- R10: `redrawAck` is a one-cycle pulse, in the cycle right after the final pixel of a frame is accepted. No new frame starts in that cycle, even if `redrawReq` is still high.
- R11: `fmtSel` is sampled when a frame starts. A change to `fmtSel` during the frame has no effect on that frame's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| redrawReq | input | 1 | Host redraw flag; a frame starts while it is high |
| redrawAck | output | 1 | One-cycle pulse when a frame completes |
| fmtSel | input | 2 | Output format: 00 RGB555, 01 RGB565, 1x 24-bit grey |
| memRdEn | output | 1 | Framebuffer read strobe |
| memAddr | output | ADDR_W | Framebuffer byte address |
| memRdData | input | 8 | Read data, valid one cycle after `memRdEn` |
| pixValid | output | 1 | Output pixel valid |
| pixReady | input | 1 | Sink accepts the pixel |
| pixData | output | 24 | Pixel in the selected format, right-aligned |
| pixSof | output | 1 | First pixel of the frame |
| pixEol | output | 1 | Last pixel of an output line |

## Verification
Two functions can fall in the same cycle, and the bench drives both. The first is back-pressure meeting a marker pixel. With random `pixReady`, the sink can stall on the last pixel of a line or on the final pixel of the frame. The bench then expects that pixel, with `pixEol` still set, to be held unchanged, and expects the acknowledge to wait for the real acceptance. The second is a redraw request arriving in the acknowledge cycle. The bench keeps `redrawReq` high through the clock edge that ends the acknowledge pulse, and then judges that no read and no pixel follow.

// File: rtl/gnx_pkg.sv
package gnx_pkg;
  localparam int PIX_W = 24;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LATCH = 2'd2,
    ST_EMIT  = 2'd3
  } gnxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchFmt;  // capture format at frame start
    logic loadByte;  // capture framebuffer byte
    logic selLow;    // 0: left (high) nibble, 1: right (low) nibble
  } gnxStrobes_t;
endpackage

// File: rtl/gnx_scan_ctrl.sv
module gnx_scan_ctrl
  import gnx_pkg::*;
#(
  parameter int SRC_ROWS  = 64,
  parameter int SRC_BYTES = 64,
  parameter int MAG       = 4,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              redrawReq,
  input  logic              pixReady,
  output logic              redrawAck,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              pixValid,
  output logic              pixSof,
  output logic              pixEol,
  output gnxStrobes_t       strb
);
  localparam int ROW_W  = (SRC_ROWS  > 1) ? $clog2(SRC_ROWS)  : 1;
  localparam int BYTE_W = (SRC_BYTES > 1) ? $clog2(SRC_BYTES) : 1;
  localparam int REP_W  = (MAG       > 1) ? $clog2(MAG)       : 1;

  gnxState_e          state;
  logic [ROW_W-1:0]   rowIdx;
  logic [REP_W-1:0]   lineRep;
  logic [BYTE_W-1:0]  byteIdx;
  logic               nibSel;
  logic [REP_W-1:0]   pixRep;

  logic lastPix, lastByte, lastLine, lastRow, startNow;

  assign lastPix  = (pixRep  == REP_W'(MAG - 1));
  assign lastByte = (byteIdx == BYTE_W'(SRC_BYTES - 1));
  assign lastLine = (lineRep == REP_W'(MAG - 1));
  assign lastRow  = (rowIdx  == ROW_W'(SRC_ROWS - 1));
  assign startNow = (state == ST_IDLE) && redrawReq && !redrawAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rowIdx    <= '0;
      lineRep   <= '0;
      byteIdx   <= '0;
      nibSel    <= 1'b0;
      pixRep    <= '0;
      redrawAck <= 1'b0;
    end else begin
      redrawAck <= 1'b0;
      unique case (state)
        ST_IDLE:  if (startNow) state <= ST_FETCH;
        ST_FETCH: state <= ST_LATCH;
        ST_LATCH: state <= ST_EMIT;
        ST_EMIT: if (pixReady) begin
          if (!lastPix) begin
            pixRep <= pixRep + REP_W'(1);
          end else begin
            pixRep <= '0;
            if (!nibSel) begin
              nibSel <= 1'b1;
            end else begin
              nibSel <= 1'b0;
              state  <= ST_FETCH;
              if (!lastByte) begin
                byteIdx <= byteIdx + BYTE_W'(1);
              end else begin
                byteIdx <= '0;
                if (!lastLine) begin
                  lineRep <= lineRep + REP_W'(1);
                end else begin
                  lineRep <= '0;
                  if (!lastRow) begin
                    rowIdx <= rowIdx + ROW_W'(1);
                  end else begin
                    rowIdx    <= '0;
                    state     <= ST_IDLE;
                    redrawAck <= 1'b1;
                  end
                end
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memRdEn  = (state == ST_FETCH);
  assign memAddr  = ADDR_W'(rowIdx) * ADDR_W'(SRC_BYTES) + ADDR_W'(byteIdx);
  assign pixValid = (state == ST_EMIT);
  assign pixSof   = pixValid && (rowIdx == '0) && (lineRep == '0) &&
                    (byteIdx == '0) && !nibSel && (pixRep == '0);
  assign pixEol   = pixValid && lastByte && nibSel && lastPix;

  assign strb.latchFmt = startNow;
  assign strb.loadByte = (state == ST_LATCH);
  assign strb.selLow   = nibSel;
endmodule

// File: rtl/gnx_scan_dp.sv
module gnx_scan_dp
  import gnx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  gnxStrobes_t      strb,
  input  logic [1:0]       fmtSel,
  input  logic [7:0]       memRdData,
  output logic [PIX_W-1:0] pixData
);
  logic [7:0] byteReg;
  logic [1:0] fmtReg;
  logic [3:0] nib;
  logic [4:0] lvl5;
  logic [5:0] grn6;
  logic [7:0] chan8;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg <= '0;
      fmtReg  <= '0;
    end else begin
      if (strb.latchFmt) fmtReg  <= fmtSel;
      if (strb.loadByte) byteReg <= memRdData;
    end
  end

  assign nib   = strb.selLow ? byteReg[3:0] : byteReg[7:4];
  assign lvl5  = {nib, nib[3]};
  assign grn6  = {lvl5, lvl5[4]};
  assign chan8 = {nib, nib};

  always_comb begin
    unique case (fmtReg)
      2'b00:   pixData = {9'd0, lvl5, lvl5, lvl5};
      2'b01:   pixData = {8'd0, lvl5, grn6, lvl5};
      default: pixData = {chan8, chan8, chan8};
    endcase
  end
endmodule

// File: rtl/gnx_scan_top.sv
module gnx_scan_top
  import gnx_pkg::*;
#(
  parameter  int SRC_ROWS  = 64,
  parameter  int SRC_BYTES = 64,
  parameter  int MAG       = 4,
  localparam int ADDR_W    = $clog2(SRC_ROWS * SRC_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              redrawReq,
  output logic              redrawAck,
  input  logic [1:0]        fmtSel,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              pixValid,
  input  logic              pixReady,
  output logic [PIX_W-1:0]  pixData,
  output logic              pixSof,
  output logic              pixEol
);
  gnxStrobes_t strb;

  gnx_scan_ctrl #(
    .SRC_ROWS(SRC_ROWS), .SRC_BYTES(SRC_BYTES), .MAG(MAG), .ADDR_W(ADDR_W)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .redrawReq(redrawReq), .pixReady(pixReady),
    .redrawAck(redrawAck), .memRdEn(memRdEn), .memAddr(memAddr),
    .pixValid(pixValid), .pixSof(pixSof), .pixEol(pixEol), .strb(strb)
  );

  gnx_scan_dp dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .fmtSel(fmtSel),
    .memRdData(memRdData), .pixData(pixData)
  );
endmodule

// File: rtl/gnx_scan_chk.sv
module gnx_scan_chk #(
  parameter int ADDR_W   = 12,
  parameter int ADDR_LIM = 4096
) (
  input logic              clk,
  input logic              rstN,
  input logic              redrawAck,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              pixValid,
  input logic              pixReady,
  input logic [23:0]       pixData,
  input logic              pixSof,
  input logic              pixEol
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady) |=> (pixValid && $stable(pixData) &&
                                 $stable(pixSof) && $stable(pixEol)));

  p_addr_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> ({1'b0, memAddr} < (ADDR_W + 1)'(ADDR_LIM)));

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    redrawAck |=> !redrawAck);

  p_ack_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    redrawAck |=> (!pixValid && !memRdEn));

  p_marker_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pixSof || pixEol) |-> pixValid);

  p_sof_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pixSof && pixReady) |=> !pixSof);
endmodule

bind gnx_scan_top gnx_scan_chk #(
  .ADDR_W(ADDR_W), .ADDR_LIM(SRC_ROWS * SRC_BYTES)
) chkI (
  .clk(clk), .rstN(rstN), .redrawAck(redrawAck), .memRdEn(memRdEn),
  .memAddr(memAddr), .pixValid(pixValid), .pixReady(pixReady),
  .pixData(pixData), .pixSof(pixSof), .pixEol(pixEol)
);

// File: tb/gnx_scan_top_tb_top.sv
module gnx_scan_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 4;
  localparam int BYTES = 4;
  localparam int MAG   = 2;
  localparam int AW    = $clog2(ROWS * BYTES);
  localparam int FRAME_PIX = ROWS * MAG * 2 * BYTES * MAG;
  localparam int WATCHDOG  = 150000;

  logic          clk = 1'b0;
  logic          rstN;
  logic          redrawReq;
  logic          redrawAck;
  logic [1:0]    fmtSel;
  logic          memRdEn;
  logic [AW-1:0] memAddr;
  logic [7:0]    memRdData;
  logic          pixValid;
  logic          pixReady;
  logic [23:0]   pixData;
  logic          pixSof;
  logic          pixEol;

  logic [7:0] mem [ROWS*BYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (memRdEn) memRdData <= mem[memAddr];

  gnx_scan_top #(.SRC_ROWS(ROWS), .SRC_BYTES(BYTES), .MAG(MAG)) dut_i (
    .clk(clk), .rstN(rstN), .redrawReq(redrawReq), .redrawAck(redrawAck),
    .fmtSel(fmtSel), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .pixValid(pixValid), .pixReady(pixReady),
    .pixData(pixData), .pixSof(pixSof), .pixEol(pixEol)
  );

  typedef struct {
    logic [23:0] d;
    logic        s;
    logic        e;
  } expPix_t;

  expPix_t     expQ[$];
  int          nChecks = 0;
  int          nFails  = 0;
  int          cycles  = 0;
  int          popped  = 0;
  bit          busy    = 1'b0;
  bit          ackDue  = 1'b0;
  bit          stallPrev = 1'b0;
  bit          readyRand = 1'b0;
  logic [23:0] prevData;
  logic        prevEol;
  logic [15:0] lfsr = 16'hACE1;
  string       fmtTag = "R4";

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] conv(input int n, input int f);
    int l5, g6, c8;
    l5 = n * 2 + (n >> 3);
    g6 = l5 * 2 + (l5 >> 4);
    c8 = n * 17;
    if (f == 0)      return 24'((l5 << 10) | (l5 << 5) | l5);
    else if (f == 1) return 24'((l5 << 11) | (g6 << 5) | l5);
    else             return 24'(c8 * 65793);
  endfunction

  task automatic buildFrame(input int f);
    expPix_t e;
    for (int r = 0; r < ROWS; r++)
      for (int lr = 0; lr < MAG; lr++)
        for (int b = 0; b < BYTES; b++)
          for (int nb = 0; nb < 2; nb++)
            for (int p = 0; p < MAG; p++) begin
              // R3: high nibble is the left pixel
              int n;
              n = (nb == 0) ? int'(mem[r*BYTES+b][7:4]) : int'(mem[r*BYTES+b][3:0]);
              e.d = conv(n, f);
              e.s = (r == 0 && lr == 0 && b == 0 && nb == 0 && p == 0);
              e.e = (b == BYTES-1 && nb == 1 && p == MAG-1);
              expQ.push_back(e);
            end
  endtask

  // ready driver, away from the sampling edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pixReady <= readyRand ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // reference comparison on every clock
  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
    if (rstN) begin
      if (ackDue) begin
        check(redrawAck == 1'b1, "R10", "ack after last pixel", redrawAck, 1);
        check(popped == FRAME_PIX, "R7", "pixels per frame", popped, FRAME_PIX);
        ackDue = 1'b0;
        busy   = 1'b0;
      end else if (redrawAck) begin
        check(1'b0, "R10", "unexpected ack", 1, 0);
      end
      if (!busy) begin
        check(!pixValid && !memRdEn, "R2", "activity while idle",
              {pixValid, memRdEn}, 0);
      end
      if (stallPrev) begin
        check(pixValid && pixData == prevData && pixEol == prevEol, "R8",
              "held pixel", pixData, prevData);
      end
      stallPrev = 1'b0;
      if (pixValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "pixel beyond frame", pixData, 0);
        end else begin
          check(pixData == expQ[0].d, fmtTag, "pixel value/order (R3 R7)",
                pixData, expQ[0].d);
          check(pixSof == expQ[0].s, "R9", "start marker", pixSof, expQ[0].s);
          check(pixEol == expQ[0].e, "R9", "line-end marker", pixEol, expQ[0].e);
          if (pixReady) begin
            void'(expQ.pop_front());
            popped++;
            if (expQ.size() == 0) ackDue = 1'b1;
          end else begin
            stallPrev = 1'b1;
            prevData  = pixData;
            prevEol   = pixEol;
          end
        end
      end
    end
  end

  task automatic runFrame(input int f, input int changeAt, input string tag);
    int k;
    fmtTag = tag;
    popped = 0;
    buildFrame(f);
    @(posedge clk); #2;
    fmtSel    = 2'(f);
    redrawReq = 1'b1;
    busy      = 1'b1;
    k = 0;
    while (busy) begin
      @(posedge clk); #2;
      k++;
      if (k == changeAt) fmtSel = ~2'(f);  // R11: mid-frame change
    end
    // request still high through the ack-ending edge (R10)
    redrawReq = 1'b0;
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    rstN      = 1'b0;
    redrawReq = 1'b0;
    fmtSel    = 2'b10;
    pixReady  = 1'b1;
    for (int i = 0; i < ROWS*BYTES; i++) mem[i] = 8'((i * 37 + 5) & 255);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!pixValid && !redrawAck && !memRdEn, "R1", "outputs in reset",
          {pixValid, redrawAck, memRdEn}, 0);
    @(posedge clk); #2;
    rstN = 1'b1;
    @(negedge clk);
    check(!pixValid && !redrawAck && !memRdEn, "R1", "outputs after reset",
          {pixValid, redrawAck, memRdEn}, 0);
    // R2: flag low, nothing happens (monitor judges each cycle)
    idleCycles(30);
    // R4: 24-bit, sink always ready
    runFrame(2, 0, "R4");
    idleCycles(20);
    // R5: RGB555 with random back-pressure
    readyRand = 1'b1;
    runFrame(0, 0, "R5");
    idleCycles(20);
    // R6: RGB565 with back-pressure
    runFrame(1, 0, "R6");
    idleCycles(10);
    // R11: format changed during the frame must be ignored
    runFrame(0, 40, "R11");
    idleCycles(10);
    // second pattern with edge nibbles, format 11 counts as 24-bit (R4)
    for (int i = 0; i < ROWS*BYTES; i++) mem[i] = {4'(i), ~4'(i)};
    mem[0] = 8'hF0;
    mem[ROWS*BYTES-1] = 8'h0F;
    runFrame(3, 0, "R4");
    idleCycles(20);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule